// File: doc/BRIEF.md
# Bidirectional Storage Bus Transceiver

This block joins two parallel buses, A and B, with one storage path in each direction. Each path takes the same four controls: an active-low output enable, an active-low clock enable, a latch-open input and a capture strobe. With these a path can pass data straight through, hold a latched value, or take in new data on a rising strobe edge. The path from A to B drives B as an open-drain bus: it pulls a bit low or lets it float, so several agents can share a wired-OR line. The path from B to A drives A as a three-state output. Both buses are carried as plain vectors so that the block can be synthesized: an input vector, an output value vector and a per-bit drive-enable vector. A wrapper at chip level, or the bench, resolves the shared lines.

All logic runs on one system clock. The two capture strobes are ordinary inputs. The block samples them on the system clock and looks for a rising edge. The paths carry no stream traffic, so there is no valid/ready handshake and no back-pressure: every pin is a plain level-sensitive control or data pin.

Top module: `dualpath_xcvr`

## Requirements
- R1: While `rst_n` is low, `a_oe` and `b_oe` are all zero. After reset, each storage element holds all ones and each strobe-edge detector is primed with the current strobe level.
- R2: When a direction's active-low output enable (`ab_oe_n`, `ba_oe_n`) is 1, that direction's drive-enable vector is all zero, whatever the other controls are. Storage still updates while the output is disabled.
- R3: While a path's latch-open input is 1 and its output is enabled, its output follows its input in the same cycle.
- R4: With latch-open at 0 and clock enable at 0, a system-clock edge at which the strobe is 1 and was 0 at the previous edge stores the input. From that edge on, the output shows the stored value.
- R5: With latch-open at 0, a strobe that stays at 1 or 0, or falls, leaves the output unchanged.
- R6: With clock enable at 1, a rising strobe is ignored and the output keeps its value.
- R7: When latch-open falls, the output keeps the input value that was present at the last system-clock edge while latch-open was still 1.
- R8: On B, `b_out` is always 0 and `b_oe[i]` is 1 exactly when the A-to-B path is enabled and its bit i is 0. A 1 therefore releases the line, and the line works as a wired-OR with other pull-down agents.
- R9: On A, when the B-to-A path is enabled, `a_oe` is all ones and `a_out` carries the path value.
- R10: The B-to-A path follows R3 to R7, using its own `ba_*` controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also forces both buses released |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | W | Per-bit three-state enable for bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value driven onto bus B (always 0, open-drain) |
| b_oe | output | W | Per-bit pull-down enable for bus B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_ce_n | input | 1 | A-to-B clock enable, active low |
| ab_le | input | 1 | A-to-B latch open (transparent when 1) |
| ab_stb | input | 1 | A-to-B capture strobe |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_ce_n | input | 1 | B-to-A clock enable, active low |
| ba_le | input | 1 | B-to-A latch open (transparent when 1) |
| ba_stb | input | 1 | B-to-A capture strobe |

## Verification
Output enables, transparent passage and reset release are combinational, so each of these results is due in the same cycle as its stimulus. A strobe capture is due only after the first system-clock rising edge that sees the strobe at 1 when it was 0 at the edge before. The bench changes inputs on the falling clock edge and compares outputs on the next falling edge, so exactly one rising edge lies between stimulus and check, which covers both kinds of result. The checks on reset-forced release are made a short delay after the reset input changes, with no clock edge in between.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic oe_n;
    logic ce_n;
    logic le;
    logic stb;
  } path_ctl_t;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  xcvr_pkg::path_ctl_t      ctl,
  input  logic [W-1:0]             d,
  output logic [W-1:0]             q
);
  logic [W-1:0] stor;
  logic         stb_q;
  logic         stb_rise;

  assign stb_rise = ctl.stb && !stb_q;

  always_ff @(posedge clk) begin
    stb_q <= ctl.stb;
    if (!rst_n) begin
      stor <= '1;
    end else if (ctl.le) begin
      stor <= d;
    end else if (!ctl.ce_n && stb_rise) begin
      stor <= d;
    end
  end

  assign q = ctl.le ? d : stor;

  AST_CLOCKED_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !ctl.ce_n && $rose(ctl.stb)) |=> (stor == $past(d))); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && !$rose(ctl.stb)) |=> $stable(stor)); // R5
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl.le && ctl.ce_n) |=> $stable(stor)); // R6
  AST_CLOSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctl.le) && $past(rst_n)) |-> (q == $past(d))); // R7
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int W          = 18,
  parameter bit OPEN_DRAIN = 1'b0
) (
  input  logic         en,
  input  logic [W-1:0] val,
  output logic [W-1:0] drv_val,
  output logic [W-1:0] drv_en
);
  generate
    if (OPEN_DRAIN) begin : g_od
      assign drv_val = '0;
      assign drv_en  = en ? ~val : '0;
    end else begin : g_ts
      assign drv_val = val;
      assign drv_en  = {W{en}};
    end
  endgenerate
endmodule

// File: rtl/dualpath_xcvr.sv
module dualpath_xcvr #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  input  logic         ab_oe_n,
  input  logic         ab_ce_n,
  input  logic         ab_le,
  input  logic         ab_stb,
  input  logic         ba_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le,
  input  logic         ba_stb
);
  import xcvr_pkg::*;

  path_ctl_t    ctl_ab, ctl_ba;
  logic [W-1:0] q_ab, q_ba;
  logic         en_ab, en_ba;

  assign ctl_ab = '{oe_n: ab_oe_n, ce_n: ab_ce_n, le: ab_le, stb: ab_stb};
  assign ctl_ba = '{oe_n: ba_oe_n, ce_n: ba_ce_n, le: ba_le, stb: ba_stb};
  assign en_ab  = rst_n && !ctl_ab.oe_n;
  assign en_ba  = rst_n && !ctl_ba.oe_n;

  xcvr_store #(.W(W)) u_st_ab (.clk(clk), .rst_n(rst_n), .ctl(ctl_ab), .d(a_in), .q(q_ab));
  xcvr_store #(.W(W)) u_st_ba (.clk(clk), .rst_n(rst_n), .ctl(ctl_ba), .d(b_in), .q(q_ba));

  xcvr_drive #(.W(W), .OPEN_DRAIN(1'b1)) u_dr_b (
    .en(en_ab), .val(q_ab), .drv_val(b_out), .drv_en(b_oe));
  xcvr_drive #(.W(W), .OPEN_DRAIN(1'b0)) u_dr_a (
    .en(en_ba), .val(q_ba), .drv_val(a_out), .drv_en(a_oe));

  AST_B_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe_n |-> (b_oe == '0)); // R2
  AST_A_RELEASED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |-> (a_oe == '0)); // R2
  AST_B_PASS_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_oe_n && ab_le) |-> (b_oe == ~a_in && b_out == '0)); // R8
  AST_A_PASS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_oe_n && ba_le) |-> (a_oe == '1 && a_out == b_in)); // R9
endmodule

// File: tb/sim_dualpath_xcvr.sv
module sim_dualpath_xcvr;
  localparam int W = 18;
  localparam logic [W-1:0] M = '1;

  typedef struct packed {
    logic oe_n, ce_n, le, stb;
    logic [W-1:0] din;
    logic [W-1:0] exp_oe;
    logic [3:0]   req;
  } vec_t;

  // A-to-B walk; the value in req is the requirement number each row checks
  localparam vec_t VECS [12] = '{
    '{1'b0,1'b1,1'b1,1'b0, 18'h3F0F0, 18'h00F0F, 4'd3},  // R3
    '{1'b0,1'b1,1'b1,1'b0, 18'h00FFF, 18'h3F000, 4'd3},  // R3
    '{1'b0,1'b1,1'b0,1'b0, 18'h15555, 18'h3F000, 4'd7},  // R7
    '{1'b0,1'b0,1'b0,1'b1, 18'h2AAAA, 18'h15555, 4'd4},  // R4
    '{1'b0,1'b0,1'b0,1'b1, 18'h12345, 18'h15555, 4'd5},  // R5
    '{1'b0,1'b0,1'b0,1'b0, 18'h12345, 18'h15555, 4'd5},  // R5
    '{1'b0,1'b1,1'b0,1'b1, 18'h0F0F0, 18'h15555, 4'd6},  // R6
    '{1'b0,1'b1,1'b0,1'b0, 18'h0F0F0, 18'h15555, 4'd6},  // R6
    '{1'b1,1'b0,1'b0,1'b1, 18'h00000, 18'h00000, 4'd2},  // R2
    '{1'b0,1'b0,1'b0,1'b1, 18'h3FFFF, 18'h3FFFF, 4'd2},  // R2 capture while off
    '{1'b1,1'b1,1'b1,1'b1, 18'h00000, 18'h00000, 4'd2},  // R2
    '{1'b0,1'b1,1'b1,1'b1, 18'h3FFFF, 18'h00000, 4'd8}   // R8
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ab_oe_n = 1'b1, ab_ce_n = 1'b1, ab_le = 1'b0, ab_stb = 1'b0;
  logic ba_oe_n = 1'b1, ba_ce_n = 1'b1, ba_le = 1'b0, ba_stb = 1'b0;
  logic [W-1:0] tb_a = '0, keeper = '0, ext_pull = '0;
  logic tb_a_en = 1'b1;
  logic [W-1:0] a_in, a_out, a_oe, b_in, b_out, b_oe, b_line;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  // bus-hold keeper on A: an undriven A keeps the last driven level
  always @(tb_a or tb_a_en) if (tb_a_en) keeper = tb_a;
  assign a_in = tb_a_en ? tb_a : keeper;
  // wired-OR B line: high unless any agent pulls it low
  assign b_line = ~(b_oe & ~b_out) & ~ext_pull & M;
  assign b_in = b_line;

  dualpath_xcvr #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_stb(ab_stb),
    .ba_oe_n(ba_oe_n), .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_stb(ba_stb));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    ab_oe_n = 1'b0;
    ba_oe_n = 1'b0;
    #1;
    chk("R1 b_oe in reset", b_oe, '0);
    chk("R1 a_oe in reset", a_oe, '0);
    ab_oe_n = 1'b1;
    ba_oe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();

    foreach (VECS[i]) begin
      {ab_oe_n, ab_ce_n, ab_le, ab_stb} = {VECS[i].oe_n, VECS[i].ce_n, VECS[i].le, VECS[i].stb};
      tb_a = VECS[i].din;
      step();
      chk($sformatf("R%0d row %0d b_oe", VECS[i].req, i), b_oe, VECS[i].exp_oe);
      chk($sformatf("R%0d row %0d b_out", VECS[i].req, i), b_out, '0);
    end

    // bus hold: A released, transparent path keeps last driven level (R3)
    tb_a = 18'h0F0F0;
    step();
    tb_a_en = 1'b0;
    tb_a = '0;
    step();
    chk("R3 bus-hold keeper", b_oe, 18'h30F0F);
    tb_a_en = 1'b1;

    // B-to-A path (R10)
    ab_oe_n = 1'b1;
    ba_oe_n = 1'b0; ba_le = 1'b1; ext_pull = 18'h00F0F;
    step();
    chk("R10 R3 a_out transparent", a_out, 18'h3F0F0);
    chk("R9 a_oe enabled", a_oe, '1);
    ba_le = 1'b0; ext_pull = '1;
    step();
    chk("R10 R7 a_out after close", a_out, 18'h3F0F0);
    ba_ce_n = 1'b0; ba_stb = 1'b1; ext_pull = '0;
    step();
    chk("R10 R4 a_out captured", a_out, 18'h3FFFF);
    ext_pull = 18'h0000F;
    step();
    chk("R10 R5 a_out strobe steady", a_out, 18'h3FFFF);
    ba_ce_n = 1'b1; ba_stb = 1'b0;
    step();
    ba_stb = 1'b1; ext_pull = '1;
    step();
    chk("R10 R6 a_out inhibited", a_out, 18'h3FFFF);
    ba_oe_n = 1'b1;
    step();
    chk("R2 a_oe released", a_oe, '0);

    // wired-OR with an outside agent on B (R8)
    ext_pull = 18'h30000;
    ab_oe_n = 1'b0; ab_le = 1'b1; tb_a = 18'h3FF00;
    step();
    chk("R8 pull enables", b_oe, 18'h000FF);
    chk("R8 wired-OR line", b_line, 18'h0FF00);

    // reset during activity releases both buses (R1)
    ba_oe_n = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 b_oe mid reset", b_oe, '0);
    chk("R1 a_oe mid reset", a_oe, '0);
    step();
    finish_run();
  end
endmodule